// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous external interrupt lines and turns selected level changes into latched pending flags and a single interrupt request pulse. Each line passes through a synchronizer. The block then compares the line with a per-line record of its last seen level. When the two differ, the record is updated. If the line's enable bit is set and the direction of the change matches one of the line's trigger selects, the line's pending flag is latched.

Software configures three per-line bit vectors through a simple write port: enable, rise select and fall select. It acknowledges events by writing ones to the pending-clear address. Any qualifying change in a cycle raises the shared request output for exactly one clock. Changes on several lines in the same cycle merge into one pulse.

Top module: `edge_irq_bank`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `pending_o` is all zero and `irq_o` is low. The stored line levels, enables and trigger selects all reset to zero.
- R2: A write with `wr_en` high loads `wr_data` into one register, chosen by `wr_addr`: 0 is the enable vector, 1 is the rise select and 2 is the fall select. Writes to addresses 4 to 7 change nothing.
- R3: A line whose enable bit is 0 never sets its pending bit, whatever its trigger selects are.
- R4: A low-to-high change on an enabled line whose rise-select bit is set does two things. It sets the line's pending bit, and it raises `irq_o`. Both become visible on the third rising clock edge after the input changes: two synchronizer stages plus one output register.
- R5: A high-to-low change on an enabled line whose fall-select bit is set sets the pending bit and raises `irq_o`, with the same latency as R4.
- R6: A change whose direction has no matching select bit sets no pending bit and raises no pulse.
- R7: A line with both selects set reports both its rising and its falling changes.
- R8: The stored level follows the line while the line is disabled. Enabling a line that already changed level therefore creates no event.
- R9: A line that holds its level produces no further events after the first change.
- R10: A write to address 3 clears every pending bit where `wr_data` is 1 and leaves the bits where it is 0. Pending bits never drop except through such a write.
- R11: If a qualifying change and a clear of the same bit fall in the same cycle, the bit stays set.
- R12: `irq_o` is high for exactly one cycle per cycle that has qualifying changes. Changes on several lines in the same cycle give one pulse and set all of their pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | LINES | External interrupt lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | LINES | Write data, one bit per line |
| pending_o | output | LINES | Latched pending flags |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The same pending bit can be set by a new edge and cleared by software in the same cycle. The bench provokes this by timing a pending-clear write to land in the cycle when a synchronized rising edge reaches the compare stage. The clear covers both that line and an older pending line. The check passes only if the bit with the new edge survives, the old bit is cleared and the pulse is still issued. A second overlap puts edges on two lines in one cycle, and the check then expects a single one-cycle pulse with both bits set.

// File: rtl/edge_irq_bank.sv
module edge_irq_bank #(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [LINES-1:0] wr_data,
  output logic [LINES-1:0] pending_o,
  output logic             irq_o
);
  localparam logic [2:0] A_ENABLE = 3'd0;
  localparam logic [2:0] A_RISE   = 3'd1;
  localparam logic [2:0] A_FALL   = 3'd2;
  localparam logic [2:0] A_CLEAR  = 3'd3;

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] level_q, enable_q, rise_q, fall_q, pend_q;
  logic [LINES-1:0] now_lvl, changed, hit, clr;
  logic             irq_q;

  assign now_lvl = sync_q[SYNC_STAGES-1];
  assign changed = now_lvl ^ level_q;
  assign hit     = changed & enable_q & ((now_lvl & rise_q) | (~now_lvl & fall_q));
  assign clr     = (wr_en && wr_addr == A_CLEAR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= line_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_ENABLE: enable_q <= wr_data;
        A_RISE:   rise_q   <= wr_data;
        A_FALL:   fall_q   <= wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      pend_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      level_q <= now_lvl;
      pend_q  <= (pend_q & ~clr) | hit;
      irq_q   <= |hit;
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/edge_irq_bank_chk.sv
module edge_irq_bank_chk #(
  parameter int LINES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [LINES-1:0] wr_data,
  input logic [LINES-1:0] pending_o,
  input logic             irq_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (pending_o == '0 && !irq_o)); // R1

  AST_NEW_PEND_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_o & ~$past(pending_o)) != '0) |-> irq_o); // R4

  AST_PULSE_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pending_o != '0)); // R12

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3) |=> (irq_o || ((pending_o & $past(wr_data)) == '0))); // R10

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd3) |=> ((pending_o & $past(pending_o)) == $past(pending_o))); // R10
endmodule

bind edge_irq_bank edge_irq_bank_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pending_o(pending_o), .irq_o(irq_o)
);

// File: tb/edge_irq_bank_bench.sv
module edge_irq_bank_bench;
  localparam int LINES = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] line_in = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [LINES-1:0] wr_data = '0;
  logic [LINES-1:0] pending_o;
  logic             irq_o;

  int n_chk = 0;
  int n_bad = 0;

  edge_irq_bank #(.LINES(LINES)) u_edge_irq_bank (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pending_o(pending_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [LINES-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd3, '1);
    @(negedge clk);
  endtask

  // drive one line, then sample at the cycle the result appears and the next
  task automatic drive(input int idx, input logic v, input logic exp_irq,
                       input logic [LINES-1:0] exp_pend, input string req);
    @(negedge clk);
    line_in[idx] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req, " irq"}, {31'd0, irq_o}, {31'd0, exp_irq});
    chk({req, " pending"}, pending_o, exp_pend);
    @(negedge clk);
    chk({req, " irq drop"}, {31'd0, irq_o}, '0);
  endtask

  task automatic t_reset();
    chk("R1 pending at reset", pending_o, '0);
    chk("R1 irq at reset", {31'd0, irq_o}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending after release", pending_o, '0);
    chk("R1 irq after release", {31'd0, irq_o}, '0);
  endtask

  task automatic t_rise();
    wr(3'd0, 32'h1); wr(3'd1, 32'h1);
    drive(0, 1'b1, 1'b1, 32'h1, "R4 rise");
    repeat (5) begin
      @(negedge clk);
      chk("R9 held level", {31'd0, irq_o}, '0);
    end
    clear_all();
  endtask

  task automatic t_fall();
    wr(3'd0, 32'h2); wr(3'd1, 32'h0); wr(3'd2, 32'h2);
    drive(1, 1'b1, 1'b0, 32'h0, "R6 rise without select");
    drive(1, 1'b0, 1'b1, 32'h2, "R5 fall");
    clear_all();
  endtask

  task automatic t_masked();
    wr(3'd0, 32'h0); wr(3'd1, 32'h4); wr(3'd2, 32'h0);
    drive(2, 1'b1, 1'b0, 32'h0, "R3 disabled line");
    wr(3'd0, 32'h4);
    repeat (4) @(negedge clk);
    chk("R8 enable after change", pending_o, '0);
    drive(2, 1'b0, 1'b0, 32'h0, "R6 fall without select");
    drive(2, 1'b1, 1'b1, 32'h4, "R8 rise after enable");
    clear_all();
  endtask

  task automatic t_both();
    wr(3'd0, 32'h8); wr(3'd1, 32'h8); wr(3'd2, 32'h8);
    drive(3, 1'b1, 1'b1, 32'h8, "R7 rise");
    clear_all();
    drive(3, 1'b0, 1'b1, 32'h8, "R7 fall");
    clear_all();
  endtask

  task automatic t_multi();
    wr(3'd0, 32'h30); wr(3'd1, 32'h30); wr(3'd2, 32'h0);
    @(negedge clk);
    line_in[4] = 1'b1; line_in[5] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 one pulse", {31'd0, irq_o}, 32'd1);
    chk("R12 both pending", pending_o, 32'h30);
    @(negedge clk);
    chk("R12 pulse one cycle", {31'd0, irq_o}, '0);
  endtask

  task automatic t_clear();
    wr(3'd3, 32'h10);
    @(negedge clk);
    chk("R10 partial clear", pending_o, 32'h20);
    clear_all();
    chk("R10 full clear", pending_o, '0);
  endtask

  task automatic t_race();
    wr(3'd0, 32'h41); wr(3'd1, 32'h41); wr(3'd2, 32'h0);
    drive(0, 1'b0, 1'b0, 32'h0, "R6 fall on rise-only line");
    drive(0, 1'b1, 1'b1, 32'h1, "R4 rise line0");
    @(negedge clk);
    line_in[6] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h41;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 edge beats clear", pending_o, 32'h40);
    chk("R11 pulse kept", {31'd0, irq_o}, 32'd1);
    clear_all();
  endtask

  task automatic t_addr();
    wr(3'd4, '1); wr(3'd5, '1); wr(3'd6, '1); wr(3'd7, '1);
    drive(7, 1'b1, 1'b0, 32'h0, "R2 unused addresses");
    wr(3'd0, 32'h80); wr(3'd2, 32'h80);
    drive(7, 1'b0, 1'b1, 32'h80, "R2 enable and fall load");
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_masked();
    t_both();
    t_multi();
    t_clear();
    t_race();
    t_addr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule